// File: doc/BRIEF.md
# Multiplexed Seven-Segment Scan Controller

This block time-multiplexes eight digits of eight segments each. It steps through the digits one at a time, from digit 0 up to a programmable last digit, and shows the segment pattern of the selected digit. The pattern comes from a 64-bit digit memory. For each digit the pattern is either the raw stored byte or a glyph from one of two selectable fonts, and the decimal point always passes through unchanged.

Each digit's slot is divided into 16 sub-steps, which produce a per-digit brightness duty. The brightness codes are stored as one byte per pair of digits. A scan tick input advances the timing. Blanking, shutdown and a display-test override decide what finally reaches the outputs.

The block is combinational from two internal counters to the outputs. A surrounding register file supplies every configuration input, and an external divider supplies the tick.

Top module: `seg_scan_ctrl`

## Requirements
- R1: After reset, and on the clock edge after clear_i is high, the controller is at digit 0, sub-step 0. clear_i has priority over tick_i.
- R2: Each clock edge with tick_i high advances a 16-step sub-step counter. The active digit moves on when the counter wraps from 15 to 0. Without a tick or a clear, nothing changes.
- R3: When the active digit d is at or above scan_limit_i as the slot ends, the next digit is 0. Otherwise the next digit is d+1. digit_o has exactly bit d set for active digit d.
- R4: Segment bit order is seg_o[7]=DP, [6]=A, [5]=B, [4]=C, [3]=D, [2]=E, [1]=F, [0]=G. When decode_en_i[d] is 0, seg_o equals byte d of digit_mem_i, taken from bits [8d+7:8d].
- R5: When decode_en_i[d] is 1, only data bits 3:0 select the glyph and bits 6:4 are ignored. Data bit 7 drives DP directly and is active high.
- R6: When hex_sel_i is 0, codes 0..15 show these A..G patterns (hex): 7E 30 6D 79 33 5B 5F 70 7F 7B 01 4F 37 0E 67 00. Codes 10..15 are dash, E, H, L, P and blank.
- R7: When hex_sel_i is 1, codes 0..15 show these A..G patterns (hex): 7E 30 6D 79 33 5B 5F 70 7F 7B 77 1F 4E 3D 4F 47. These are the digits 0..9 and the letters A..F.
- R8: For a brightness code n, segments are lit while the sub-step is below n+1 when n is 0..14, and below 15 when n is 15. digit_o stays active for the whole slot.
- R9: Byte p of intensity_i serves digits 2p and 2p+1. The low nibble belongs to the even digit and the high nibble to the odd digit.
- R10: While shutdown_i is high and test_i is low, digit_o and seg_o are 0. The digit memory and the scan position are kept.
- R11: While blank_i is high and test_i is low, digit_o and seg_o are 0.
- R12: While test_i is high, digit_o and seg_o are all ones, whatever shutdown_i, blank_i and scan_limit_i are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous restart at digit 0 |
| tick_i | input | 1 | Sub-step advance strobe |
| blank_i | input | 1 | Force all outputs off |
| shutdown_i | input | 1 | Shutdown, outputs off |
| test_i | input | 1 | Display test, all outputs on |
| hex_sel_i | input | 1 | Font select: 0 code-B, 1 hex |
| scan_limit_i | input | 3 | Last scanned digit |
| decode_en_i | input | 8 | Per-digit decode enable |
| intensity_i | input | 32 | Brightness codes, one byte per digit pair |
| digit_mem_i | input | 64 | Digit data, byte d for digit d |
| digit_o | output | 8 | One-hot active digit |
| seg_o | output | 8 | Segment enables, DP..G |

## Verification
The raw path is driven with arbitrary bytes. All 32 combinations of font select and code are driven with junk in data bits 6:4 and an alternating DP bit. This separates the two fonts, shows that bits 6:4 are masked, and shows that DP bypasses the decoder. The brightness gate is swept through every sub-step of two adjacent digits with different nibbles of the same pair byte, which exposes an off-by-one in the duty and a swapped nibble. Scan limits 1 and 2 exercise the wrap. Clear is applied mid-slot, and shutdown and blank are each checked with test both low and high to confirm the priority between them.

// File: rtl/seg_scan_pkg.sv
`timescale 1ns/1ps
package seg_scan_pkg;
  localparam int unsigned GLYPH_W = 7;

  // A..G in bits 6..0
  function automatic logic [GLYPH_W-1:0] glyph(input logic [3:0] code, input logic hex);
    logic [GLYPH_W-1:0] g;
    unique case (code)
      4'd0:  g = 7'h7E;
      4'd1:  g = 7'h30;
      4'd2:  g = 7'h6D;
      4'd3:  g = 7'h79;
      4'd4:  g = 7'h33;
      4'd5:  g = 7'h5B;
      4'd6:  g = 7'h5F;
      4'd7:  g = 7'h70;
      4'd8:  g = 7'h7F;
      4'd9:  g = 7'h7B;
      4'd10: g = hex ? 7'h77 : 7'h01;
      4'd11: g = hex ? 7'h1F : 7'h4F;
      4'd12: g = hex ? 7'h4E : 7'h37;
      4'd13: g = hex ? 7'h3D : 7'h0E;
      4'd14: g = hex ? 7'h4F : 7'h67;
      default: g = hex ? 7'h47 : 7'h00;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/seg_scan_timer.sv
`timescale 1ns/1ps
module seg_scan_timer #(
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned SUB_STEPS  = 16,
  localparam int unsigned DIG_W = $clog2(NUM_DIGITS),
  localparam int unsigned SUB_W = $clog2(SUB_STEPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [DIG_W-1:0] limit_i,
  output logic [DIG_W-1:0] dig_o,
  output logic [SUB_W-1:0] sub_o
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_STEPS - 1);

  logic [DIG_W-1:0] dig_q;
  logic [SUB_W-1:0] sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dig_q <= '0;
      sub_q <= '0;
    end else if (clear_i) begin
      dig_q <= '0;
      sub_q <= '0;
    end else if (tick_i) begin
      sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
      if (sub_q == SUB_LAST) begin
        dig_q <= (dig_q >= limit_i) ? '0 : dig_q + 1'b1;
      end
    end
  end

  assign dig_o = dig_q;
  assign sub_o = sub_q;
endmodule

// File: rtl/seg_glyph_dec.sv
`timescale 1ns/1ps
module seg_glyph_dec #(
  parameter int unsigned SEG_W = 8
) (
  input  logic [SEG_W-1:0] data_i,
  input  logic             dec_en_i,
  input  logic             hex_i,
  output logic [SEG_W-1:0] seg_o
);
  import seg_scan_pkg::*;

  always_comb begin
    if (dec_en_i) seg_o = {data_i[SEG_W-1], glyph(data_i[3:0], hex_i)};
    else          seg_o = data_i;
  end
endmodule

// File: rtl/seg_pwm_gate.sv
`timescale 1ns/1ps
module seg_pwm_gate #(
  parameter int unsigned SUB_STEPS = 16,
  localparam int unsigned SUB_W = $clog2(SUB_STEPS)
) (
  input  logic [SUB_W-1:0] sub_i,
  input  logic [SUB_W-1:0] code_i,
  output logic             on_o
);
  localparam logic [SUB_W-1:0] CODE_MAX = SUB_W'(SUB_STEPS - 1);
  logic [SUB_W:0] duty;

  // top code saturates at (steps-1)/steps
  assign duty = (code_i == CODE_MAX) ? (SUB_W+1)'(CODE_MAX) : {1'b0, code_i} + 1'b1;
  assign on_o = ({1'b0, sub_i} < duty);
endmodule

// File: rtl/seg_scan_ctrl.sv
`timescale 1ns/1ps
module seg_scan_ctrl #(
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned SEG_W      = 8,
  parameter int unsigned SUB_STEPS  = 16,
  localparam int unsigned DIG_W = $clog2(NUM_DIGITS),
  localparam int unsigned SUB_W = $clog2(SUB_STEPS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic                        tick_i,
  input  logic                        blank_i,
  input  logic                        shutdown_i,
  input  logic                        test_i,
  input  logic                        hex_sel_i,
  input  logic [DIG_W-1:0]            scan_limit_i,
  input  logic [NUM_DIGITS-1:0]       decode_en_i,
  input  logic [NUM_DIGITS*SUB_W-1:0] intensity_i,
  input  logic [NUM_DIGITS*SEG_W-1:0] digit_mem_i,
  output logic [NUM_DIGITS-1:0]       digit_o,
  output logic [SEG_W-1:0]            seg_o
);
  logic [DIG_W-1:0] dig_idx;
  logic [SUB_W-1:0] sub_cnt;
  logic [SEG_W-1:0] mem_arr [NUM_DIGITS];
  logic [SUB_W-1:0] lvl_arr [NUM_DIGITS];
  logic [SEG_W-1:0] pat;
  logic             pwm_on;

  seg_scan_timer #(.NUM_DIGITS(NUM_DIGITS), .SUB_STEPS(SUB_STEPS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .tick_i  (tick_i),
    .limit_i (scan_limit_i),
    .dig_o   (dig_idx),
    .sub_o   (sub_cnt)
  );

  // pair byte: even digit low nibble, odd digit high nibble -> nibble d
  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_unpack
    assign mem_arr[d] = digit_mem_i[d*SEG_W +: SEG_W];
    assign lvl_arr[d] = intensity_i[d*SUB_W +: SUB_W];
  end

  seg_glyph_dec #(.SEG_W(SEG_W)) u_dec (
    .data_i   (mem_arr[dig_idx]),
    .dec_en_i (decode_en_i[dig_idx]),
    .hex_i    (hex_sel_i),
    .seg_o    (pat)
  );

  seg_pwm_gate #(.SUB_STEPS(SUB_STEPS)) u_pwm (
    .sub_i  (sub_cnt),
    .code_i (lvl_arr[dig_idx]),
    .on_o   (pwm_on)
  );

  always_comb begin
    if (test_i) begin
      digit_o = '1;
      seg_o   = '1;
    end else if (blank_i || shutdown_i) begin
      digit_o = '0;
      seg_o   = '0;
    end else begin
      digit_o = NUM_DIGITS'(1) << dig_idx;
      seg_o   = pwm_on ? pat : '0;
    end
  end
endmodule

// File: rtl/seg_scan_chk.sv
`timescale 1ns/1ps
module seg_scan_chk #(
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned SEG_W      = 8,
  parameter int unsigned SUB_STEPS  = 16,
  localparam int unsigned DIG_W = $clog2(NUM_DIGITS),
  localparam int unsigned SUB_W = $clog2(SUB_STEPS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  clear_i,
  input logic                  tick_i,
  input logic                  blank_i,
  input logic                  shutdown_i,
  input logic                  test_i,
  input logic [DIG_W-1:0]      scan_limit_i,
  input logic [NUM_DIGITS-1:0] digit_o,
  input logic [SEG_W-1:0]      seg_o,
  input logic [DIG_W-1:0]      dig_idx,
  input logic [SUB_W-1:0]      sub_cnt
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_STEPS - 1);

  p_clear_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (dig_idx == '0 && sub_cnt == '0));

  p_sub_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clear_i) |=> sub_cnt == SUB_W'($past(sub_cnt) + 1'b1));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> ($stable(sub_cnt) && $stable(dig_idx)));

  p_limit_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clear_i && sub_cnt == SUB_LAST && dig_idx >= scan_limit_i) |=> dig_idx == '0);

  p_digit_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clear_i && sub_cnt == SUB_LAST && dig_idx < scan_limit_i)
      |=> dig_idx == DIG_W'($past(dig_idx) + 1'b1));

  p_digit_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_i |-> $onehot0(digit_o));

  p_shutdown_dark_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_i && !test_i) |-> (digit_o == '0 && seg_o == '0));

  p_blank_dark_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && !test_i) |-> (digit_o == '0 && seg_o == '0));

  p_test_all_on_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |-> ($countones(digit_o) == NUM_DIGITS && $countones(seg_o) == SEG_W));
endmodule

bind seg_scan_ctrl seg_scan_chk #(
  .NUM_DIGITS (NUM_DIGITS),
  .SEG_W      (SEG_W),
  .SUB_STEPS  (SUB_STEPS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_i      (clear_i),
  .tick_i       (tick_i),
  .blank_i      (blank_i),
  .shutdown_i   (shutdown_i),
  .test_i       (test_i),
  .scan_limit_i (scan_limit_i),
  .digit_o      (digit_o),
  .seg_o        (seg_o),
  .dig_idx      (dig_idx),
  .sub_cnt      (sub_cnt)
);

// File: tb/seg_scan_ctrl_tb.sv
`timescale 1ns/1ps
module seg_scan_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        tick_i = 1'b0;
  logic        blank_i = 1'b0;
  logic        shutdown_i = 1'b0;
  logic        test_i = 1'b0;
  logic        hex_sel_i = 1'b0;
  logic [2:0]  scan_limit_i = 3'd7;
  logic [7:0]  decode_en_i = 8'h00;
  logic [31:0] intensity_i = 32'h0;
  logic [63:0] digit_mem_i = 64'h0;
  logic [7:0]  digit_o;
  logic [7:0]  seg_o;

  typedef struct {
    logic [7:0] dig;
    logic [7:0] seg;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  event sample_ev;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #2 clk_i = ~clk_i;

  seg_scan_ctrl u_dut (
    .clk_i, .rst_ni, .clear_i, .tick_i, .blank_i, .shutdown_i, .test_i,
    .hex_sel_i, .scan_limit_i, .decode_en_i, .intensity_i, .digit_mem_i,
    .digit_o, .seg_o
  );

  // expected glyphs from R6 / R7
  function automatic logic [6:0] exp_glyph(input int code, input bit hex);
    logic [6:0] cb [16] = '{7'h7E, 7'h30, 7'h6D, 7'h79, 7'h33, 7'h5B, 7'h5F, 7'h70,
                            7'h7F, 7'h7B, 7'h01, 7'h4F, 7'h37, 7'h0E, 7'h67, 7'h00};
    logic [6:0] hx [16] = '{7'h7E, 7'h30, 7'h6D, 7'h79, 7'h33, 7'h5B, 7'h5F, 7'h70,
                            7'h7F, 7'h7B, 7'h77, 7'h1F, 7'h4E, 7'h3D, 7'h4F, 7'h47};
    return hex ? hx[code] : cb[code];
  endfunction

  // monitor: pops and compares when the driver asks for a sample
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (digit_o !== e.dig || seg_o !== e.seg) begin
          n_errors++;
          $display("FAIL %s: digit=%h seg=%h expected digit=%h seg=%h",
                   e.tag, digit_o, seg_o, e.dig, e.seg);
        end
      end
    end
  end

  task automatic expect_out(input logic [7:0] dig, input logic [7:0] seg, input string tag);
    exp_t e;
    @(negedge clk_i);
    #1;
    e.dig = dig; e.seg = seg; e.tag = tag;
    sb_q.push_back(e);
    ->sample_ev;
    wait (sb_q.size() == 0);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic do_clear();
    @(negedge clk_i); clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    digit_mem_i[7:0] = 8'hA5;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    expect_out(8'h01, 8'hA5, "R1 reset at digit 0 sub 0");

    shutdown_i = 1'b1;
    expect_out(8'h00, 8'h00, "R10 shutdown dark");
    shutdown_i = 1'b0;
    expect_out(8'h01, 8'hA5, "R10 data kept after shutdown");

    digit_mem_i[7:0] = 8'h3C;
    expect_out(8'h01, 8'h3C, "R4 raw mapping");

    // fonts with junk in bits 6:4, DP alternating
    decode_en_i = 8'h01;
    for (int h = 0; h < 2; h++) begin
      for (int c = 0; c < 16; c++) begin
        hex_sel_i = h[0];
        digit_mem_i[7:0] = {c[0], 3'b101, c[3:0]};
        expect_out(8'h01, {c[0], exp_glyph(c, h[0])}, h ? "R7 R5 hex font" : "R6 R5 code-B font");
      end
    end

    // PWM sweep, pair nibbles
    decode_en_i = 8'h00;
    digit_mem_i[15:0] = 16'hFFFF;
    intensity_i[7:0] = 8'h23;
    scan_limit_i = 3'd1;
    do_clear();
    for (int s = 0; s < 16; s++) begin
      expect_out(8'h01, (s < 4) ? 8'hFF : 8'h00, "R8 R9 even digit duty 4/16");
      step(1);
    end
    for (int s = 0; s < 16; s++) begin
      expect_out(8'h02, (s < 3) ? 8'hFF : 8'h00, "R2 R9 odd digit duty 3/16");
      step(1);
    end
    expect_out(8'h01, 8'hFF, "R3 wrap at limit 1");

    intensity_i[3:0] = 4'hF;
    step(14);
    expect_out(8'h01, 8'hFF, "R8 code 15 lit at sub 14");
    step(1);
    expect_out(8'h01, 8'h00, "R8 code 15 dark at sub 15");
    intensity_i[3:0] = 4'hE;
    expect_out(8'h01, 8'h00, "R8 code 14 dark at sub 15");

    // limit 2 with clear
    scan_limit_i = 3'd2;
    digit_mem_i[23:16] = 8'h11;
    do_clear();
    step(16);
    expect_out(8'h02, 8'hFF, "R3 digit 1 under limit 2");
    step(16);
    expect_out(8'h04, 8'h11, "R3 digit 2 under limit 2");
    step(16);
    expect_out(8'h01, 8'hFF, "R3 wrap at limit 2");
    step(21);
    expect_out(8'h02, 8'h00, "R2 digit 1 mid-slot");
    do_clear();
    expect_out(8'h01, 8'hFF, "R1 clear mid-scan");
    @(negedge clk_i); clear_i = 1'b1; tick_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0; tick_i = 1'b0;
    intensity_i[3:0] = 4'h0;
    expect_out(8'h01, 8'hFF, "R1 clear beats tick");

    blank_i = 1'b1;
    expect_out(8'h00, 8'h00, "R11 blank dark");
    test_i = 1'b1;
    shutdown_i = 1'b1;
    expect_out(8'hFF, 8'hFF, "R12 test over blank and shutdown");
    blank_i = 1'b0;
    expect_out(8'hFF, 8'hFF, "R12 test over shutdown");
    test_i = 1'b0;
    expect_out(8'h00, 8'h00, "R10 shutdown after test");
    shutdown_i = 1'b0;
    expect_out(8'h01, 8'hFF, "R12 contents unchanged after test");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule